// File: doc/BRIEF.md
# In-Order Issue Group Selector

This block sits between the fetch side and the reservation stations of a superscalar core. Each cycle it decides which instructions leave for execution. The result is an issue group: a mask over up to `W` slot positions, and the mask may be empty. A fetch group is offered on a valid/ready pair. Each slot of the group carries three things: a class code naming the reservation station it needs, a branch flag, and a count of extra issue cycles. The reservation stations report, every cycle, how many entries are free in each class.

The selector cuts a fetch group just after its first branch. It then issues the oldest instructions for which entries are free and keeps the rest. The kept instructions are retried on later cycles, ahead of any new fetch. A group whose members need extra issue cycles is held back: one empty group is emitted for each extra cycle, and the held group is emitted after them. The issue mask is registered, so a decision made at a rising edge appears at the output right after that edge.

Top module: `issue_group_sel`

## Requirements
- R1: While reset is high and in the cycle after it falls, `iss_mask` is all zeros and `fg_ready` is 1.
- R2: `fg_ready` is 1 exactly when nothing is left from an earlier group, no selected group is waiting out extra cycles, and the extra-cycle counter is zero. A fetch group is taken only at an edge where `fg_valid` and `fg_ready` are both 1.
- R3: The selector finds the lowest-numbered slot that has both `fg_slot_vld` and `fg_branch` set. Slots numbered above it in that group are dropped and are never issued. Bit i of `iss_mask` always refers to slot i of the group currently held.
- R4: Selection runs from slot 0 upward. It stops at the first pending slot whose class has no free entry left. That slot and every higher slot stay pending, so each nonzero issue mask is one contiguous run of bits.
- R5: Free counts are taken from `rs_free` in the cycle of the decision. Field k (bits k*CNT_W upward) is the count for class k. Each selected slot uses one entry of its class, so n slots of one class need n free entries.
- R6: Slots left pending by a stall are retried on the following cycles, lowest first. No new fetch group is taken while any slot is pending.
- R7: Let E be the largest extra-cycle value among the slots selected in a decision. If E is greater than 0, `iss_mask` shows zero for E cycles, starting with the decision cycle, and shows the selected slots in the cycle after those. If E is 0, the selected slots appear straight away.
- R8: Each cycle's action follows a fixed priority. A pending bubble comes first, then a waiting selected group, then retry of pending slots, then acceptance of a valid fetch group. With none of these, the output is an empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fg_valid | input | 1 | A fetch group is offered |
| fg_ready | output | 1 | The selector will take the offered group at this edge |
| fg_slot_vld | input | W | Per-slot valid of the offered group |
| fg_cls | input | W*CLS_W | Per-slot class code, slot i in bits i*CLS_W upward |
| fg_branch | input | W | Per-slot branch flag |
| fg_extra | input | W*XW | Per-slot extra issue cycles, slot i in bits i*XW upward |
| rs_free | input | NCLS*CNT_W | Free reservation-station entries per class |
| iss_mask | output | W | Registered issue group: slots of the held group issued this cycle |

## Verification
The assertions take three things for granted about the inputs. Class codes are below NCLS, which must be a power of two. The free counts on `rs_free` belong to the cycle in which they are sampled. The offered group does not matter while `fg_ready` is low. The stimulus draws class codes and free counts only from their legal ranges, and it changes every input, including a non-accepted fetch group, on falling edges. This keeps each decision edge-clean and shows that offers made while the selector is busy are ignored. Free counts of zero are drawn often, so stalls and retries are frequent. Nonzero extra-cycle values are mixed in at a lower rate.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;

  // Action taken in one cycle, listed from highest to lowest priority after idle
  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_BUBBLE,
    DEC_WAIT,
    DEC_RETRY,
    DEC_FETCH
  } issue_dec_e;

endpackage

// File: rtl/issue_trunc.sv
module issue_trunc #(
  parameter int W = 4
) (
  input  logic [W-1:0] slot_vld,
  input  logic [W-1:0] branch,
  output logic [W-1:0] keep
);

  // Keep every valid slot up to and including the first valid branch
  always_comb begin
    logic seen;
    seen = 1'b0;
    keep = '0;
    for (int i = 0; i < W; i++) begin
      keep[i] = slot_vld[i] && !seen;
      if (slot_vld[i] && branch[i]) seen = 1'b1;
    end
  end

  // R3: a kept branch has no kept slot above it
  always_comb begin
    for (int i = 0; i < W; i++) begin
      for (int j = i + 1; j < W; j++) begin
        a_r3_cut_after_branch: assert (!(keep[i] && branch[i] && keep[j]));
      end
    end
  end

endmodule

// File: rtl/issue_pick.sv
module issue_pick #(
  parameter int W     = 4,
  parameter int NCLS  = 4,
  parameter int CLS_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [W-1:0]          cand,
  input  logic [W*CLS_W-1:0]    cls,
  input  logic [NCLS*CNT_W-1:0] free,
  output logic [W-1:0]          sel
);

  // In-order selection, consuming free entries slot by slot
  always_comb begin
    logic [CNT_W-1:0] left [NCLS];
    logic             go;
    logic [CLS_W-1:0] c;
    for (int k = 0; k < NCLS; k++) left[k] = free[k*CNT_W +: CNT_W];
    go  = 1'b1;
    sel = '0;
    c   = '0;
    for (int i = 0; i < W; i++) begin
      c = cls[i*CLS_W +: CLS_W];
      if (go && cand[i]) begin
        if (left[c] != '0) begin
          sel[i]  = 1'b1;
          left[c] = left[c] - CNT_W'(1);
        end else begin
          go = 1'b0;
        end
      end
    end
  end

  // R5: no class receives more slots than it has free entries
  always_comb begin
    for (int k = 0; k < NCLS; k++) begin
      int n;
      n = 0;
      for (int i = 0; i < W; i++)
        if (sel[i] && (int'(cls[i*CLS_W +: CLS_W]) == k)) n++;
      a_r5_class_budget: assert (n <= int'(free[k*CNT_W +: CNT_W]));
    end
  end

endmodule

// File: rtl/issue_xmax.sv
module issue_xmax #(
  parameter int W  = 4,
  parameter int XW = 2
) (
  input  logic [W-1:0]    sel,
  input  logic [W*XW-1:0] ext,
  output logic [XW-1:0]   emax
);

  always_comb begin
    emax = '0;
    for (int i = 0; i < W; i++)
      if (sel[i] && (ext[i*XW +: XW] > emax)) emax = ext[i*XW +: XW];
  end

endmodule

// File: rtl/issue_group_sel.sv
module issue_group_sel
  import issue_sel_pkg::*;
#(
  parameter int W     = 4,
  parameter int NCLS  = 4,
  parameter int CNT_W = 3,
  parameter int XW    = 2,
  localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fg_valid,
  output logic                  fg_ready,
  input  logic [W-1:0]          fg_slot_vld,
  input  logic [W*CLS_W-1:0]    fg_cls,
  input  logic [W-1:0]          fg_branch,
  input  logic [W*XW-1:0]       fg_extra,
  input  logic [NCLS*CNT_W-1:0] rs_free,
  output logic [W-1:0]          iss_mask
);

  // Held group state
  logic [W*CLS_W-1:0] held_cls;
  logic [W*XW-1:0]    held_ext;
  logic [W-1:0]       pend;
  logic               wait_q;
  logic [W-1:0]       wait_mask;
  logic [XW-1:0]      xcnt;

  issue_dec_e         dec;
  logic [W-1:0]       fetch_keep;
  logic [W-1:0]       cand_mask;
  logic [W*CLS_W-1:0] cand_cls;
  logic [W*XW-1:0]    cand_ext;
  logic [W-1:0]       pick_sel;
  logic [XW-1:0]      pick_emax;

  issue_trunc #(.W(W)) u_trunc (
    .slot_vld (fg_slot_vld),
    .branch   (fg_branch),
    .keep     (fetch_keep)
  );

  // Priority: bubble, waiting group, retry, new fetch
  always_comb begin
    if (xcnt != '0)        dec = DEC_BUBBLE;
    else if (wait_q)       dec = DEC_WAIT;
    else if (pend != '0)   dec = DEC_RETRY;
    else if (fg_valid)     dec = DEC_FETCH;
    else                   dec = DEC_IDLE;
  end

  assign fg_ready = (xcnt == '0) && !wait_q && (pend == '0);

  assign cand_mask = (dec == DEC_FETCH) ? fetch_keep : pend;
  assign cand_cls  = (dec == DEC_FETCH) ? fg_cls     : held_cls;
  assign cand_ext  = (dec == DEC_FETCH) ? fg_extra   : held_ext;

  issue_pick #(.W(W), .NCLS(NCLS), .CLS_W(CLS_W), .CNT_W(CNT_W)) u_pick (
    .cand (cand_mask),
    .cls  (cand_cls),
    .free (rs_free),
    .sel  (pick_sel)
  );

  issue_xmax #(.W(W), .XW(XW)) u_xmax (
    .sel  (pick_sel),
    .ext  (cand_ext),
    .emax (pick_emax)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      held_cls  <= '0;
      held_ext  <= '0;
      pend      <= '0;
      wait_q    <= 1'b0;
      wait_mask <= '0;
      xcnt      <= '0;
      iss_mask  <= '0;
    end else begin
      case (dec)
        DEC_BUBBLE: begin
          iss_mask <= '0;
          xcnt     <= xcnt - XW'(1);
        end
        DEC_WAIT: begin
          iss_mask <= wait_mask;
          wait_q   <= 1'b0;
        end
        DEC_RETRY, DEC_FETCH: begin
          if (dec == DEC_FETCH) begin
            held_cls <= fg_cls;
            held_ext <= fg_extra;
          end
          pend <= cand_mask & ~pick_sel;
          if (pick_emax != '0) begin
            iss_mask  <= '0;
            xcnt      <= pick_emax - XW'(1);
            wait_q    <= 1'b1;
            wait_mask <= pick_sel;
          end else begin
            iss_mask <= pick_sel;
          end
        end
        default: iss_mask <= '0;
      endcase
    end
  end

  // R4: an issued group is one contiguous run of slots
  logic [W-1:0] iss_lsb;
  assign iss_lsb = iss_mask & (~iss_mask + W'(1));

  a_r4_contiguous: assert property (@(posedge clk) disable iff (rst)
    ((iss_mask + iss_lsb) & iss_mask) == '0);

  // R7: a counted bubble yields an empty group
  a_r7_bubble_empty: assert property (@(posedge clk) disable iff (rst)
    (xcnt != '0) |=> (iss_mask == '0));

  // R7: once bubbles are done the waiting group goes out
  a_r7_wait_release: assert property (@(posedge clk) disable iff (rst)
    (wait_q && (xcnt == '0)) |=> (iss_mask != '0));

endmodule

// File: tb/issue_group_sel_tb.sv
module issue_group_sel_tb;

  localparam int W     = 4;
  localparam int NCLS  = 4;
  localparam int CNT_W = 3;
  localparam int XW    = 2;
  localparam int CLS_W = 2;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  fg_valid = 1'b0;
  logic                  fg_ready;
  logic [W-1:0]          fg_slot_vld = '0;
  logic [W*CLS_W-1:0]    fg_cls = '0;
  logic [W-1:0]          fg_branch = '0;
  logic [W*XW-1:0]       fg_extra = '0;
  logic [NCLS*CNT_W-1:0] rs_free = '0;
  logic [W-1:0]          iss_mask;

  always #5 clk = ~clk;

  issue_group_sel #(.W(W), .NCLS(NCLS), .CNT_W(CNT_W), .XW(XW)) u_dut (
    .clk, .rst, .fg_valid, .fg_ready, .fg_slot_vld, .fg_cls,
    .fg_branch, .fg_extra, .rs_free, .iss_mask
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference state
  logic [W-1:0]       m_pend;
  logic [W*CLS_W-1:0] m_cls;
  logic [W*XW-1:0]    m_ext;
  int                 m_xcnt;
  bit                 m_wait;
  logic [W-1:0]       m_wmask;

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] f_keep(logic [W-1:0] v, logic [W-1:0] b);
    logic [W-1:0] k = '0;
    for (int i = 0; i < W; i++) begin
      k[i] = v[i];
      if (v[i] && b[i]) break;
    end
    return k;
  endfunction

  function automatic logic [W-1:0] f_pick(logic [W-1:0] cand, logic [W*CLS_W-1:0] cls,
                                          logic [NCLS*CNT_W-1:0] free);
    int left [NCLS];
    logic [W-1:0] s = '0;
    for (int k = 0; k < NCLS; k++) left[k] = int'(free[k*CNT_W +: CNT_W]);
    for (int i = 0; i < W; i++) begin
      int c;
      if (!cand[i]) continue;
      c = int'(cls[i*CLS_W +: CLS_W]);
      if (left[c] == 0) break;
      left[c]--;
      s[i] = 1'b1;
    end
    return s;
  endfunction

  // One cycle: check ready now, model the edge, check the mask after it
  task automatic step(string tag);
    bit exp_rdy;
    logic [W-1:0] exp_mask;
    logic [W-1:0] cand, s;
    string t;
    int e;
    exp_rdy = (m_xcnt == 0) && !m_wait && (m_pend == '0);
    chk("R2 ready", {{(W-1){1'b0}}, fg_ready}, {{(W-1){1'b0}}, exp_rdy});
    exp_mask = '0;
    if (m_xcnt != 0) begin
      m_xcnt--; t = "R7 bubble";
    end else if (m_wait) begin
      exp_mask = m_wmask; m_wait = 1'b0; t = "R7 release";
    end else if (m_pend != '0 || fg_valid) begin
      if (m_pend != '0) begin
        cand = m_pend; t = "R6 retry";
      end else begin
        cand = f_keep(fg_slot_vld, fg_branch);
        m_cls = fg_cls; m_ext = fg_extra; t = "R4 fetch";
      end
      s = f_pick(cand, m_cls, rs_free);
      m_pend = cand & ~s;
      e = 0;
      for (int i = 0; i < W; i++)
        if (s[i] && int'(m_ext[i*XW +: XW]) > e) e = int'(m_ext[i*XW +: XW]);
      if (e > 0) begin
        m_xcnt = e - 1; m_wait = 1'b1; m_wmask = s; t = "R7 hold";
      end else begin
        exp_mask = s;
      end
    end else begin
      t = "R8 idle";
    end
    @(negedge clk);
    chk((tag != "") ? tag : t, iss_mask, exp_mask);
  endtask

  task automatic set_all_free(int n);
    for (int k = 0; k < NCLS; k++) rs_free[k*CNT_W +: CNT_W] = CNT_W'(n);
  endtask

  task automatic drive_rand();
    int n;
    fg_valid = ($urandom % 10) < 7;
    n = 1 + int'($urandom % W);
    fg_slot_vld = W'((1 << n) - 1);
    for (int i = 0; i < W; i++) begin
      fg_branch[i] = ($urandom % 100) < 15;
      fg_cls[i*CLS_W +: CLS_W] = CLS_W'($urandom % NCLS);
      fg_extra[i*XW +: XW] = (($urandom % 10) < 8) ? XW'(0) : XW'(1 + $urandom % 3);
    end
    for (int k = 0; k < NCLS; k++)
      rs_free[k*CNT_W +: CNT_W] = (($urandom % 4) == 0) ? CNT_W'(0) : CNT_W'($urandom % 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a001));
    m_pend = '0; m_cls = '0; m_ext = '0; m_xcnt = 0; m_wait = 1'b0; m_wmask = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset mask", iss_mask, '0);
    rst = 1'b0;
    chk("R1 reset ready", {{(W-1){1'b0}}, fg_ready}, {{(W-1){1'b0}}, 1'b1});

    // R3: branch at slot 1 drops slots 2 and 3
    set_all_free(3);
    fg_valid = 1'b1; fg_slot_vld = 4'b1111; fg_branch = 4'b0010;
    fg_cls = '0; fg_extra = '0;
    step("R3 truncate");
    fg_valid = 1'b0; fg_branch = '0;
    step("R8 idle");

    // R5/R6: three class-2 slots, two entries free, then retry
    fg_valid = 1'b1; fg_slot_vld = 4'b0111;
    for (int i = 0; i < W; i++) fg_cls[i*CLS_W +: CLS_W] = 2'd2;
    set_all_free(3); rs_free[2*CNT_W +: CNT_W] = 3'd2;
    step("R5 same class");
    fg_slot_vld = 4'b1111;
    step("R6 retry");
    fg_valid = 1'b0;
    step("R8 idle");

    // R4: class 1 blocked at slot 1 stops slots 2 and 3 too
    fg_valid = 1'b1; fg_slot_vld = 4'b1111;
    fg_cls = {2'd0, 2'd0, 2'd1, 2'd0};
    set_all_free(3); rs_free[1*CNT_W +: CNT_W] = 3'd0;
    step("R4 in order stall");
    fg_valid = 1'b0;
    step("R6 still blocked");
    set_all_free(3);
    step("R6 retry");

    // R7: largest extra of 2 gives two empty groups then the group
    fg_valid = 1'b1; fg_slot_vld = 4'b0011; fg_cls = '0;
    fg_extra = {2'd0, 2'd0, 2'd0, 2'd2};
    step("R7 hold");
    fg_valid = 1'b0; fg_extra = '0;
    step("R7 bubble");
    step("R7 release");
    step("R8 idle");

    for (int c = 0; c < 3000; c++) begin
      drive_rand();
      step("");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule